// File: doc/BRIEF.md
# Shared Memory Bus Arbiter with Posted Host Writes

This block lets two masters share one internal memory bus: a host-side slave port with separate read and write strobes and a wait output, and an embedded processor that fetches from flash and reads or writes SRAM. Only one access runs on the bus at a time. Its length is set by a programmable wait-state count for the memory that the address selects.

A host write goes into a one-entry holding register, so the host strobe can finish while the processor still owns the bus. The held write is retired to memory at the next point where the bus is handed over, ahead of anything else. A host read cannot be served early, so the host is stalled on the wait output until the memory read has returned its data. After a held write retires, a processor that is still requesting gets the bus before a waiting host read. After a processor access, a waiting host read goes first. This means one processor fetch can sit between a held write and the host read that follows it.

Top module: `membus_arbiter`

## Requirements
- R1: After reset, `host_wait` and `mem_cyc` are 0 and `bus_owner` reads 0 (idle).
- R2: Address bit AW-1 set selects flash (`mem_flash`=1), clear selects SRAM. Every bus access lasts 1 + the wait-state count of its target memory (`ws_flash` or `ws_sram`), with `mem_last` high in its final cycle and `mem_addr` held steady until then.
- R3: A host write that finds the holding register empty is taken without `host_wait` ever rising.
- R4: A host write that finds the holding register full keeps `host_wait` high until the held write has been retired, and is taken after that. Its data reaches memory.
- R5: A held write is granted the bus at the next hand-over point (idle, or the last cycle of the current access), before any other requester.
- R6: When a held write finishes and the processor is requesting, the processor is granted next. When a processor access finishes and a host read is waiting, the host read is granted next.
- R7: If no write is held and the previous grant did not go to the processor, a processor request beats a host read that arrives in the same cycle.
- R8: A host read keeps `host_wait` high from the first cycle of its strobe. `host_wait` falls in the cycle after the read's final bus cycle, and `host_rdata` then holds the memory data.
- R9: `host_wait` never stays high for 53 consecutive clock cycles.
- R10: `cpu_done` is high in the final cycle of each processor access, and `cpu_rdata` then carries the memory read data.
- `bus_owner` encoding: 0 idle, 1 processor, 2 held host write, 3 host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe, held until `host_wait` is low |
| host_wr | input | 1 | Host write strobe, held until `host_wait` is low |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, valid when `host_wait` drops |
| host_wait | output | 1 | Stalls the host strobe |
| ws_flash | input | WSW | Flash wait-state count |
| ws_sram | input | WSW | SRAM wait-state count |
| cpu_req | input | 1 | Processor wants an access, sampled at hand-over points |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data |
| cpu_done | output | 1 | Final cycle of a processor access |
| mem_cyc | output | 1 | A bus access is in progress |
| mem_flash | output | 1 | Access targets flash |
| mem_we | output | 1 | Access is a write |
| mem_last | output | 1 | Final cycle of the access |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, sampled in the final cycle |
| bus_owner | output | 2 | Current owner of the bus (encoding in the requirements) |

## Verification
Two functions can fall in the same cycle: a held write retiring, and a new host write arriving while the register is still full. The same goes for a processor access ending at the very edge where a host read first asks. The bench runs the processor back to back and places host strobes one cycle apart, so these edges coincide. It judges the result by the exact stall count that the wait-state settings predict, by the order of grants, and by the read-back data. Random host traffic over four wait-state settings then mixes these coincidences freely, with a shadow memory to check the data.

// File: rtl/membus_arbiter.sv
`timescale 1ns/1ps
module membus_arbiter #(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_wait,
  input  logic [WSW-1:0] ws_flash,
  input  logic [WSW-1:0] ws_sram,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           cpu_done,
  output logic           mem_cyc,
  output logic           mem_flash,
  output logic           mem_we,
  output logic           mem_last,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [1:0]     bus_owner
);
  localparam logic [1:0] OWN_IDLE = 2'd0, OWN_CPU = 2'd1, OWN_PW = 2'd2, OWN_HRD = 2'd3;

  logic [1:0]     owner, nxt;
  logic [WSW-1:0] cnt, nxt_ws;
  logic [AW-1:0]  cur_addr, pw_addr, nxt_addr;
  logic [DW-1:0]  cur_wdata, pw_wdata, nxt_wdata, rd_q;
  logic           cur_we, nxt_we, pw_valid, wr_acc, rd_done, last_cpu;

  wire done    = (owner != OWN_IDLE) && (cnt == '0);
  wire decide  = (owner == OWN_IDLE) || done;
  wire pw_eff  = pw_valid && !(done && owner == OWN_PW);
  wire hrd_req = host_rd && !rd_done;
  wire hrd_eff = hrd_req && !(done && owner == OWN_HRD);
  wire wr_take = host_wr && !wr_acc && !pw_valid;

  always_comb begin
    if (pw_eff)                   nxt = OWN_PW;
    else if (hrd_eff && last_cpu) nxt = OWN_HRD;
    else if (cpu_req)             nxt = OWN_CPU;
    else if (hrd_eff)             nxt = OWN_HRD;
    else                          nxt = OWN_IDLE;
  end

  always_comb begin
    case (nxt)
      OWN_PW:  begin nxt_addr = pw_addr;   nxt_wdata = pw_wdata;  nxt_we = 1'b1;   end
      OWN_HRD: begin nxt_addr = host_addr; nxt_wdata = '0;        nxt_we = 1'b0;   end
      default: begin nxt_addr = cpu_addr;  nxt_wdata = cpu_wdata; nxt_we = cpu_we; end
    endcase
    nxt_ws = nxt_addr[AW-1] ? ws_flash : ws_sram;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner     <= OWN_IDLE;
      cnt       <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_we    <= 1'b0;
      last_cpu  <= 1'b0;
    end else if (decide) begin
      owner     <= nxt;
      cnt       <= nxt_ws;
      cur_addr  <= nxt_addr;
      cur_wdata <= nxt_wdata;
      cur_we    <= nxt_we && (nxt != OWN_IDLE);
      if (nxt == OWN_CPU)       last_cpu <= 1'b1;
      else if (nxt != OWN_IDLE) last_cpu <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_valid <= 1'b0;
      pw_addr  <= '0;
      pw_wdata <= '0;
      wr_acc   <= 1'b0;
    end else begin
      if (done && owner == OWN_PW) pw_valid <= 1'b0;
      if (wr_take) begin
        pw_valid <= 1'b1;
        pw_addr  <= host_addr;
        pw_wdata <= host_wdata;
      end
      if (!host_wr)     wr_acc <= 1'b0;
      else if (wr_take) wr_acc <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_done <= 1'b0;
      rd_q    <= '0;
    end else if (!host_rd) begin
      rd_done <= 1'b0;
    end else if (done && owner == OWN_HRD) begin
      rd_done <= 1'b1;
      rd_q    <= mem_rdata;
    end
  end

  assign host_wait  = (host_wr && !wr_acc && pw_valid) || hrd_req;
  assign host_rdata = rd_q;
  assign cpu_done   = done && owner == OWN_CPU;
  assign cpu_rdata  = mem_rdata;
  assign mem_cyc    = owner != OWN_IDLE;
  assign mem_last   = done;
  assign mem_addr   = cur_addr;
  assign mem_flash  = mem_cyc && cur_addr[AW-1];
  assign mem_we     = mem_cyc && cur_we;
  assign mem_wdata  = cur_wdata;
  assign bus_owner  = owner;
endmodule

module membus_arbiter_chk #(
  parameter int AW = 12,
  parameter int WSW = 2,
  parameter int WAIT_LIMIT = 53
) (
  input logic           clk,
  input logic           rst_n,
  input logic           host_rd,
  input logic           host_wait,
  input logic           cpu_req,
  input logic           mem_cyc,
  input logic           mem_last,
  input logic           pw_valid,
  input logic           last_cpu,
  input logic [AW-1:0]  mem_addr,
  input logic [WSW-1:0] ws_flash,
  input logic [WSW-1:0] ws_sram,
  input logic [1:0]     bus_owner
);
  logic [7:0] len, wc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len <= '0;
      wc  <= '0;
    end else begin
      len <= (mem_cyc && !mem_last) ? len + 8'd1 : 8'd0;
      wc  <= host_wait ? ((wc == 8'hFF) ? wc : wc + 8'd1) : 8'd0;
    end
  end

  AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_last |-> (len == (mem_addr[AW-1] ? 8'(ws_flash) : 8'(ws_sram)))); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc && !mem_last) |=> $stable(mem_addr)); // R2
  AST_PW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && bus_owner != 2'd2 && (mem_last || bus_owner == 2'd0)) |=> bus_owner == 2'd2); // R5
  AST_CPU_AFTER_PW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_last && bus_owner == 2'd2 && cpu_req) |=> bus_owner == 2'd1); // R6
  AST_HRD_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_last && bus_owner == 2'd1 && host_rd && host_wait && !pw_valid) |=> bus_owner == 2'd3); // R6
  AST_CPU_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owner == 2'd0 && cpu_req && !pw_valid && !last_cpu) |=> bus_owner == 2'd1); // R7
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && $fell(host_wait)) |-> $past(mem_last && bus_owner == 2'd3)); // R8
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wc < 8'(WAIT_LIMIT)); // R9
endmodule

bind membus_arbiter membus_arbiter_chk #(.AW(AW), .WSW(WSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wait(host_wait),
  .cpu_req(cpu_req), .mem_cyc(mem_cyc), .mem_last(mem_last),
  .pw_valid(pw_valid), .last_cpu(last_cpu), .mem_addr(mem_addr),
  .ws_flash(ws_flash), .ws_sram(ws_sram), .bus_owner(bus_owner));

// File: tb/test_membus_arbiter.sv
`timescale 1ns/1ps
module test_membus_arbiter;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_wait;
  logic [11:0] host_addr = '0, cpu_addr = 12'h800, mem_addr;
  logic [15:0] host_wdata = '0, host_rdata, cpu_rdata, mem_wdata, mem_rdata;
  logic [1:0]  ws_flash = 2'd3, ws_sram = 2'd3, bus_owner;
  logic        cpu_req = 1'b0, cpu_done, mem_cyc, mem_flash, mem_we, mem_last;
  logic [15:0] sram [16];
  logic [15:0] shadow [16];
  logic [1:0]  glog [1024];
  int          glog_n = 0, checks = 0, failures = 0, cpu_mode = 0, len = 0, wrun = 0;
  logic        prev_cyc = 1'b0, prev_last = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  membus_arbiter i_membus_arbiter (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .ws_flash(ws_flash), .ws_sram(ws_sram),
    .cpu_req(cpu_req), .cpu_we(1'b0), .cpu_addr(cpu_addr), .cpu_wdata(16'h0),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .mem_cyc(mem_cyc),
    .mem_flash(mem_flash), .mem_we(mem_we), .mem_last(mem_last),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .bus_owner(bus_owner));

  function automatic logic [15:0] rom(input logic [11:0] a);
    return {4'hA, a} ^ 16'h5A5A;
  endfunction

  function automatic int exp_len(input logic [11:0] a, input logic [1:0] wf, input logic [1:0] wsr);
    return 1 + (a[11] ? int'(wf) : int'(wsr));
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @* mem_rdata = mem_addr[11] ? rom(mem_addr) : sram[mem_addr[3:0]];
  always @(posedge clk) if (mem_cyc && mem_last && mem_we && !mem_addr[11]) sram[mem_addr[3:0]] <= mem_wdata;

  always @(negedge clk) begin
    #2;
    if (cpu_done && cpu_req) chk(cpu_rdata == rom(cpu_addr), "R10 cpu data", cpu_rdata, rom(cpu_addr));
    case (cpu_mode)
      0: cpu_req = 1'b0;
      1: cpu_req = 1'b1;
      default: begin
        if (!cpu_req) begin
          if ($urandom % 2 == 0) begin cpu_req = 1'b1; cpu_addr = {1'b1, 11'($urandom)}; end
        end else if (cpu_done) begin
          if ($urandom % 3 == 0) cpu_req = 1'b0;
          else cpu_addr = {1'b1, 11'($urandom)};
        end
      end
    endcase
  end

  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (mem_cyc) begin
        len++;
        if (!prev_cyc || prev_last) begin
          if (glog_n < 1024) glog[glog_n] = bus_owner;
          glog_n++;
        end
        if (mem_last) begin
          chk(len == exp_len(mem_addr, ws_flash, ws_sram), "R2 cycle length", len, exp_len(mem_addr, ws_flash, ws_sram));
          chk(mem_flash == mem_addr[11], "R2 decode", mem_flash, mem_addr[11]);
          len = 0;
        end
      end
      wrun = host_wait ? wrun + 1 : 0;
      if (wrun == 53) chk(1'b0, "R9 wait bound", wrun, 52);
      prev_cyc = mem_cyc;
      prev_last = mem_last;
    end
  end

  task automatic host_write(input logic [11:0] a, input logic [15:0] d, output int nw);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1; shadow[a[3:0]] = d; nw = 0;
    #1;
    while (host_wait) begin nw++; @(negedge clk); #1; end
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, output logic [15:0] d, output int nw);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1; nw = 0;
    #1;
    while (host_wait) begin nw++; @(negedge clk); #1; end
    d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic settle();
    cpu_mode = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    int nw, nr, g0;
    logic [15:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin sram[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(host_wait == 1'b0, "R1 wait", host_wait, 0);
    chk(mem_cyc == 1'b0, "R1 mem_cyc", mem_cyc, 0);
    chk(bus_owner == 2'd0, "R1 owner", bus_owner, 0);

    // worst case: fetch, posted write, fetch, host read
    @(negedge clk);
    g0 = glog_n;
    cpu_mode = 1;
    host_write(12'h005, 16'hBEEF, nw);
    chk(nw == 0, "R3 write without wait", nw, 0);
    host_read(12'h005, d, nr);
    chk(nr == int'(ws_flash) - 1 + 2 * (int'(ws_sram) + 1) + int'(ws_flash) + 1, "R8 read wait count", nr, 14);
    chk(d == 16'hBEEF, "R8 read data", d, 16'hBEEF);
    chk(glog[g0] == 2'd1, "R6 grant 1 cpu", glog[g0], 1);
    chk(glog[g0+1] == 2'd2, "R5 grant 2 posted write", glog[g0+1], 2);
    chk(glog[g0+2] == 2'd1, "R6 grant 3 cpu", glog[g0+2], 1);
    chk(glog[g0+3] == 2'd3, "R6 grant 4 host read", glog[g0+3], 3);
    settle();

    // full holding register
    cpu_mode = 1;
    host_write(12'h00A, 16'h1111, nw);
    chk(nw == 0, "R3 first write", nw, 0);
    host_write(12'h00B, 16'h2222, nw);
    chk(nw == int'(ws_flash) - 1 + int'(ws_sram) + 1, "R4 second write wait", nw, 6);
    settle();
    host_read(12'h00A, d, nr);
    chk(d == 16'h1111, "R4 first data", d, 16'h1111);
    host_read(12'h00B, d, nr);
    chk(d == 16'h2222, "R4 second data", d, 16'h2222);
    settle();

    // tie: processor and host read in the same cycle, last grant was a host read
    g0 = glog_n;
    fork
      begin @(negedge clk); cpu_mode = 1; end
      host_read(12'h005, d, nr);
    join
    chk(glog[g0] == 2'd1, "R7 cpu wins tie", glog[g0], 1);
    chk(glog[g0+1] == 2'd3, "R7 host read next", glog[g0+1], 3);
    chk(nr == int'(ws_flash) + int'(ws_sram) + 3, "R7 tie read wait", nr, 9);
    chk(d == 16'hBEEF, "R8 tie read data", d, 16'hBEEF);
    settle();

    // random traffic across wait-state settings
    for (int p = 0; p < 4; p++) begin
      ws_flash = 2'(p * 3 + 1);
      ws_sram = 2'(p + 2);
      cpu_mode = 2;
      for (int k = 0; k < 60; k++) begin
        logic [11:0] a;
        a = {8'h00, 4'($urandom)};
        if ($urandom % 2 == 0) host_write(a, 16'($urandom), nw);
        else begin
          host_read(a, d, nr);
          chk(d == shadow[a[3:0]], "R8 random read data", d, shadow[a[3:0]]);
        end
      end
      settle();
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
    end
  end
endmodule